// File: doc/BRIEF.md
# Shared-Line Store Handshake Controller

This controller decides when the volatile array of a nonvolatile memory is copied into its persistent cells, and it coordinates that copy with other devices over one shared, wired-low busy line. Any device may pull the line low. A device that sees another one pull the line starts its own store, so a group of parts wired to the same line save together. A store also starts when software asks for one. The array engine carries out the store in two phases: it first clears the old persistent contents and then programs every bit at once. It reports the end of each phase with a done pulse.

The controller also gates the accesses of the volatile array. A read or write strobe is granted one cycle later only while the memory is enabled. The memory-enable output is registered. It drops during a store and during a recall from the persistent cells. After a store, and also after an externally requested store that was skipped, the memory stays disabled until the synchronized line is truly back high. A store requested over the line is performed only if a write has happened since the last store. A software request always performs one.

Top module: `shared_store_ctrl`

## Requirements
- R1: Out of reset, linePullEn is 0, arrCmd is 2'b00, rdGo and wrGo are 0, and memEn is 1.
- R2: In the idle state with recallBusy low, an accRd or accWr strobe produces rdGo or wrGo one cycle later, and an accepted write marks the contents as modified.
- R3: An external low on lineIn shorter than MIN_PULSE clock cycles has no effect. A low of MIN_PULSE cycles or more opens a grace window.
- R4: During the grace window memEn stays 1 for GRACE_CYC cycles, and the store decision is taken when the window ends. Any access strobe inside the window ends it at once and is not granted.
- R5: A write attempted inside the grace window is not granted, and a store of modified contents begins on the next cycle.
- R6: A store requested over the line is skipped when nothing was written since the last store. A swStoreReq pulse always performs the store.
- R7: While a store runs, linePullEn is 1 and memEn is 0. linePullEn drops when the program phase reports done.
- R8: arrCmd first shows 2'b01 (clear) until arrDone, then 2'b10 (program) until arrDone, then returns to 2'b00. A completed store clears the modified mark.
- R9: After a store or a skipped store, memEn stays 0 as long as the synchronized line is low. It returns SYNC_STAGES+1 cycles after lineIn goes high.
- R10: The controller's own pull-down is never taken for an external request, so a finished store does not start another one.
- R11: While recallBusy is 1, memEn is 0 one cycle later, no access is granted, and no store is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| lineIn | input | 1 | Raw level of the shared busy line |
| linePullEn | output | 1 | Enables the open-drain pull-down on the shared line |
| accRd | input | 1 | Read access strobe |
| accWr | input | 1 | Write access strobe |
| swStoreReq | input | 1 | One-cycle software store request |
| recallBusy | input | 1 | High while persistent data is being restored |
| arrCmd | output | 2 | Array phase: 00 none, 01 clear, 10 program |
| arrDone | input | 1 | One-cycle pulse ending the current phase |
| memEn | output | 1 | Registered enable of the volatile array |
| rdGo | output | 1 | Granted read, one cycle after the strobe |
| wrGo | output | 1 | Granted write, one cycle after the strobe |

## Verification
Each result has a fixed delay after its stimulus. Grants, recall gating and a software store show up one cycle after the strobe. A line low that begins at cycle 0 starts the pull-down at cycle SYNC_STAGES+MIN_PULSE+GRACE_CYC. A release of the line re-enables the memory SYNC_STAGES+1 cycles later. The bench drives inputs on the falling edge and counts falling edges from the stimulus. It checks each output at exactly the computed count, and at the count just before it where the old value must still hold. Phase order comes from a log kept by the bench's model of the array engine.

// File: rtl/shst_pkg.sv
package shst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GRACE, ST_ERASE, ST_PROG, ST_HOLD
  } ctlState_e;

  localparam logic [1:0] CMD_NONE  = 2'b00;
  localparam logic [1:0] CMD_ERASE = 2'b01;
  localparam logic [1:0] CMD_PROG  = 2'b10;

  typedef struct packed {
    logic       memOn;
    logic       pullOn;
    logic       rdOk;
    logic       wrOk;
    logic       clrDirty;
    logic       graceRun;
    logic [1:0] cmd;
  } ctlStrobe_t;

  typedef struct packed {
    logic extHit;
    logic graceEnd;
    logic lineHigh;
    logic dirty;
  } dpStatus_t;
endpackage

// File: rtl/shst_datapath.sv
module shst_datapath
  import shst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int GRACE_CYC   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineRaw,
  input  ctlStrobe_t strb,
  output dpStatus_t  stat,
  output logic       memEnQ,
  output logic       pullQ,
  output logic       rdQ,
  output logic       wrQ,
  output logic [1:0] cmdQ
);
  localparam int LCW = $clog2(MIN_PULSE + 1);
  localparam int GCW = $clog2(GRACE_CYC + 1);
  localparam logic [LCW-1:0] LOW_SAT = LCW'(MIN_PULSE - 1);
  localparam logic [GCW-1:0] GRACE_LAST = GCW'(GRACE_CYC - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [SYNC_STAGES-1:0] ownHist;
  logic [LCW-1:0] lowCnt;
  logic [GCW-1:0] graceCnt;
  logic graceQ, dirtyQ;
  logic lineS, ownMask, extLow;

  assign lineS   = syncQ[SYNC_STAGES-1];
  assign ownMask = pullQ | (|ownHist);
  assign extLow  = !lineS && !ownMask;

  // line synchronizer and history of own pull-down, same depth
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '1;
      ownHist <= '0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], lineRaw};
      ownHist <= {ownHist[SYNC_STAGES-2:0], pullQ};
    end
  end

  // external low-time and grace-window counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      graceCnt <= '0;
    end else begin
      if (!extLow) lowCnt <= '0;
      else if (lowCnt < LOW_SAT) lowCnt <= lowCnt + 1'b1;
      if (!graceQ) graceCnt <= '0;
      else if (graceCnt < GRACE_LAST) graceCnt <= graceCnt + 1'b1;
    end
  end

  // registered outputs and modified mark
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memEnQ <= 1'b1;
      pullQ  <= 1'b0;
      rdQ    <= 1'b0;
      wrQ    <= 1'b0;
      cmdQ   <= CMD_NONE;
      graceQ <= 1'b0;
      dirtyQ <= 1'b0;
    end else begin
      memEnQ <= strb.memOn;
      pullQ  <= strb.pullOn;
      rdQ    <= strb.rdOk;
      wrQ    <= strb.wrOk;
      cmdQ   <= strb.cmd;
      graceQ <= strb.graceRun;
      if (strb.clrDirty) dirtyQ <= 1'b0;
      else if (strb.wrOk) dirtyQ <= 1'b1;
    end
  end

  assign stat.extHit   = extLow && (lowCnt >= LOW_SAT);
  assign stat.graceEnd = graceQ && (graceCnt == GRACE_LAST);
  assign stat.lineHigh = lineS && !ownMask;
  assign stat.dirty    = dirtyQ;

  p_pull_blocks_mem_r7: assert property (@(posedge clk) disable iff (!rstN)
    pullQ |-> !memEnQ);
  p_cmd_with_pull_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ != CMD_NONE) |-> pullQ);
  p_grant_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdQ || wrQ) |-> memEnQ);
  p_own_pull_masked_r10: assert property (@(posedge clk) disable iff (!rstN)
    pullQ |-> !stat.extHit);
endmodule

// File: rtl/shst_control.sv
module shst_control
  import shst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accRd,
  input  logic       accWr,
  input  logic       swStoreReq,
  input  logic       recallBusy,
  input  logic       arrDone,
  input  dpStatus_t  stat,
  output ctlStrobe_t strb
);
  ctlState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (!recallBusy) begin
          if (swStoreReq)       nextState = ST_ERASE;
          else if (stat.extHit) nextState = ST_GRACE;
        end
      end
      ST_GRACE: begin
        if (stat.graceEnd || accRd || accWr)
          nextState = stat.dirty ? ST_ERASE : ST_HOLD;
      end
      ST_ERASE: if (arrDone) nextState = ST_PROG;
      ST_PROG: begin
        if (arrDone) begin
          nextState     = ST_HOLD;
          strb.clrDirty = 1'b1;
        end
      end
      ST_HOLD: if (stat.lineHigh) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase

    strb.memOn    = (nextState == ST_IDLE || nextState == ST_GRACE) && !recallBusy;
    strb.pullOn   = (nextState == ST_ERASE || nextState == ST_PROG);
    strb.graceRun = (nextState == ST_GRACE);
    strb.cmd      = (nextState == ST_ERASE) ? CMD_ERASE :
                    (nextState == ST_PROG)  ? CMD_PROG  : CMD_NONE;
    strb.rdOk     = accRd && (state == ST_IDLE) && strb.memOn;
    strb.wrOk     = accWr && (state == ST_IDLE) && strb.memOn;
  end

  p_prog_after_erase_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> ($past(state) == ST_ERASE || $past(state) == ST_PROG));
  p_skip_only_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) == ST_GRACE) |-> !$past(stat.dirty));
  p_hold_until_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !stat.lineHigh) |=> (state == ST_HOLD));
  p_grace_write_stores_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GRACE && accWr) |=> (state == ST_ERASE || state == ST_HOLD));
  p_recall_no_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && recallBusy) |=> (state == ST_IDLE));
endmodule

// File: rtl/shared_store_ctrl.sv
module shared_store_ctrl
  import shst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int GRACE_CYC   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  output logic       linePullEn,
  input  logic       accRd,
  input  logic       accWr,
  input  logic       swStoreReq,
  input  logic       recallBusy,
  output logic [1:0] arrCmd,
  input  logic       arrDone,
  output logic       memEn,
  output logic       rdGo,
  output logic       wrGo
);
  ctlStrobe_t strb;
  dpStatus_t  stat;

  shst_control u_ctl (
    .clk(clk), .rstN(rstN), .accRd(accRd), .accWr(accWr),
    .swStoreReq(swStoreReq), .recallBusy(recallBusy), .arrDone(arrDone),
    .stat(stat), .strb(strb)
  );

  shst_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE), .GRACE_CYC(GRACE_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .lineRaw(lineIn), .strb(strb), .stat(stat),
    .memEnQ(memEn), .pullQ(linePullEn), .rdQ(rdGo), .wrQ(wrGo), .cmdQ(arrCmd)
  );
endmodule

// File: tb/sim_shared_store_ctrl.sv
module sim_shared_store_ctrl;
  localparam int CLK_PER = 10;
  localparam int SYNC = 2;
  localparam int MINP = 4;
  localparam int GRC  = 8;
  localparam int ENG_DLY = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic extDrv = 1'b0, accRd = 1'b0, accWr = 1'b0, swStoreReq = 1'b0;
  logic recallBusy = 1'b0, arrDone = 1'b0;
  logic linePullEn, memEn, rdGo, wrGo, lineIn;
  logic [1:0] arrCmd;
  int total = 0, bad = 0;
  int eraseCnt = 0, progCnt = 0, orderBad = 0;
  logic [1:0] lastPhase = 2'b00;

  assign lineIn = !(extDrv || linePullEn);

  always #(CLK_PER/2) clk = ~clk;

  shared_store_ctrl #(.SYNC_STAGES(SYNC), .MIN_PULSE(MINP), .GRACE_CYC(GRC)) u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .linePullEn(linePullEn),
    .accRd(accRd), .accWr(accWr), .swStoreReq(swStoreReq), .recallBusy(recallBusy),
    .arrCmd(arrCmd), .arrDone(arrDone), .memEn(memEn), .rdGo(rdGo), .wrGo(wrGo)
  );

  // array engine model: one done pulse per phase, logs the phase order
  initial begin
    logic [1:0] seen;
    seen = 2'b00;
    forever begin
      @(negedge clk);
      if (arrCmd != 2'b00 && arrCmd != seen) begin
        seen = arrCmd;
        if (arrCmd == 2'b01) begin
          eraseCnt++;
          if (lastPhase == 2'b01) orderBad++;
        end else begin
          progCnt++;
          if (lastPhase != 2'b01) orderBad++;
        end
        lastPhase = arrCmd;
        repeat (ENG_DLY - 1) @(negedge clk);
        arrDone = 1'b1;
        @(negedge clk);
        arrDone = 1'b0;
      end else if (arrCmd == 2'b00) begin
        seen = 2'b00;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitStoreEnd(output int cyc);
    cyc = 0;
    while (linePullEn && cyc < 200) begin
      tick(1);
      cyc++;
    end
  endtask

  task automatic doWrite();
    accWr = 1'b1; tick(1); accWr = 1'b0;
    chk(wrGo == 1'b1, "R2 write grant", int'(wrGo), 1);
  endtask

  task automatic t_reset();
    chk(linePullEn == 1'b0, "R1 pull", int'(linePullEn), 0);
    chk(arrCmd == 2'b00, "R1 cmd", int'(arrCmd), 0);
    chk(memEn == 1'b1, "R1 memEn", int'(memEn), 1);
    chk(rdGo == 1'b0 && wrGo == 1'b0, "R1 grants", int'({rdGo, wrGo}), 0);
  endtask

  task automatic t_access();
    accRd = 1'b1; tick(1); accRd = 1'b0;
    chk(rdGo == 1'b1, "R2 read grant", int'(rdGo), 1);
    tick(1);
    chk(rdGo == 1'b0, "R2 read pulse ends", int'(rdGo), 0);
  endtask

  task automatic t_short_pulse();
    int badSeen;
    badSeen = 0;
    extDrv = 1'b1; tick(MINP - 1); extDrv = 1'b0;
    for (int k = 0; k < GRC + 10; k++) begin
      tick(1);
      if (!memEn || linePullEn) badSeen++;
    end
    chk(badSeen == 0, "R3 short low ignored", badSeen, 0);
    doWrite();
  endtask

  // modified contents: long-enough low, grace runs to its end, store, hold
  task automatic t_ext_store();
    int k, cyc, e0, p0;
    e0 = eraseCnt; p0 = progCnt;
    doWrite();
    extDrv = 1'b1;
    k = 0;
    while (!linePullEn && k < 60) begin
      tick(1); k++;
      if (k == MINP) extDrv = 1'b0;
      if (k == SYNC + MINP + GRC - 1)
        chk(memEn == 1'b1, "R4 memEn kept in grace", int'(memEn), 1);
    end
    chk(k == SYNC + MINP + GRC, "R4 store after grace", k, SYNC + MINP + GRC);
    chk(memEn == 1'b0, "R7 memEn low in store", int'(memEn), 0);
    chk(arrCmd == 2'b01, "R8 clear first", int'(arrCmd), 1);
    waitStoreEnd(cyc);
    chk(eraseCnt == e0 + 1 && progCnt == p0 + 1 && orderBad == 0,
        "R8 phase order", progCnt - p0, 1);
    chk(arrCmd == 2'b00, "R8 cmd idle", int'(arrCmd), 0);
    tick(SYNC);
    chk(memEn == 1'b0, "R9 still locked", int'(memEn), 0);
    tick(1);
    chk(memEn == 1'b1, "R9 unlocked", int'(memEn), 1);
  endtask

  // clean contents: request over the line is skipped but locks until line high
  task automatic t_clean_skip();
    int e0;
    e0 = eraseCnt;
    extDrv = 1'b1;
    tick(SYNC + MINP + GRC - 1);
    chk(memEn == 1'b1, "R4 grace open", int'(memEn), 1);
    tick(1);
    chk(memEn == 1'b0, "R9 locked after skip", int'(memEn), 0);
    tick(10);
    chk(memEn == 1'b0 && linePullEn == 1'b0, "R9 held while low", int'(memEn), 0);
    chk(eraseCnt == e0, "R6 clean skip", eraseCnt - e0, 0);
    extDrv = 1'b0;
    tick(SYNC);
    chk(memEn == 1'b0, "R9 release delay", int'(memEn), 0);
    tick(1);
    chk(memEn == 1'b1, "R9 release", int'(memEn), 1);
  endtask

  task automatic t_grace_write();
    int cyc, e0;
    doWrite();
    e0 = eraseCnt;
    extDrv = 1'b1; tick(MINP); extDrv = 1'b0;
    tick(SYNC);
    accWr = 1'b1; tick(1); accWr = 1'b0;
    chk(wrGo == 1'b0, "R5 grace write dropped", int'(wrGo), 0);
    chk(linePullEn == 1'b1, "R5 store at once", int'(linePullEn), 1);
    waitStoreEnd(cyc);
    chk(eraseCnt == e0 + 1, "R5 store performed", eraseCnt - e0, 1);
    tick(SYNC + 1);
    chk(memEn == 1'b1, "R9 back after store", int'(memEn), 1);
  endtask

  task automatic t_grace_read();
    extDrv = 1'b1; tick(MINP); extDrv = 1'b0;
    tick(SYNC);
    accRd = 1'b1; tick(1); accRd = 1'b0;
    chk(rdGo == 1'b0 && memEn == 1'b0, "R4 early end by read", int'({rdGo, memEn}), 0);
    chk(linePullEn == 1'b0, "R6 early clean skip", int'(linePullEn), 0);
    tick(1);
    chk(memEn == 1'b1, "R9 line already high", int'(memEn), 1);
  endtask

  task automatic t_sw_store();
    int cyc, e0, extra;
    e0 = eraseCnt;
    swStoreReq = 1'b1; tick(1); swStoreReq = 1'b0;
    chk(linePullEn == 1'b1 && arrCmd == 2'b01, "R6 sw store on clean", int'(arrCmd), 1);
    waitStoreEnd(cyc);
    extra = 0;
    for (int k = 0; k < 30; k++) begin
      tick(1);
      if (linePullEn) extra++;
    end
    chk(eraseCnt == e0 + 1 && extra == 0, "R10 no self retrigger", eraseCnt - e0, 1);
    chk(memEn == 1'b1, "R10 memEn back", int'(memEn), 1);
  endtask

  task automatic t_recall();
    recallBusy = 1'b1; accRd = 1'b1; tick(1); accRd = 1'b0;
    chk(memEn == 1'b0 && rdGo == 1'b0, "R11 recall gates", int'({memEn, rdGo}), 0);
    swStoreReq = 1'b1; tick(1); swStoreReq = 1'b0;
    chk(linePullEn == 1'b0, "R11 no store in recall", int'(linePullEn), 0);
    recallBusy = 1'b0; tick(1);
    chk(memEn == 1'b1, "R11 recall end", int'(memEn), 1);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_access();
    t_short_pulse();
    t_ext_store();
    t_clean_skip();
    t_grace_write();
    t_grace_read();
    t_sw_store();
    t_recall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule